// File: doc/BRIEF.md
# Unmapped-Read Value Generator

When the processor reads from address space that no device decodes, the bus still has to return a word. This block builds that word from what sits in the instruction pipeline. In the 32-bit instruction mode it returns the prefetched opcode. In the 16-bit compact mode it combines two halfwords. One is the low half of the prefetched opcode and the other is the low half of the decoded opcode. The memory page the program counter sits in, and in one page also its word alignment, decide which halfword goes where.

The assembled word is then shifted right by the byte offset of the faulting access, so a narrower read takes the low bits of the result. Detecting unmapped accesses and running the pipeline are done elsewhere. A one-cycle request strobe marks the cycle in which the inputs are valid. The result is registered and appears one cycle later with a valid flag.

Top module: `obr_value_gen`

## Requirements
- R1: While reset is asserted and after its release with no request, `obr_valid` is 0 and `obr_data` is 0.
- R2: With `compact_mode`=0 (32-bit instruction mode) and `addr_lo`=0, `obr_data` equals `pf_word` unchanged.
- R3: With `compact_mode`=1 and `pc_page` equal to 0x00 or 0x07, the word before shifting is {pf_word[15:0], dec_half} (prefetched halfword in bits 31:16).
- R4: With `compact_mode`=1, `pc_page`=0x03 and `pc_lo`=0, the word before shifting is {dec_half, pf_word[15:0]}.
- R5: With `compact_mode`=1, `pc_page`=0x03 and `pc_lo` nonzero, the word before shifting is {pf_word[15:0], dec_half}.
- R6: With `compact_mode`=1 and any other `pc_page`, the word before shifting is {pf_word[15:0], pf_word[15:0]}.
- R7: The result is the assembled word shifted right by 8×`addr_lo` bits, with zeros filled in from the top.
- R8: `obr_valid` is 1 exactly in the cycle after a cycle with `obr_req`=1. In a cycle after `obr_req`=0, `obr_data` keeps its value whatever the other inputs do.
- R9: In compact mode, `pf_word[31:16]` has no effect on `obr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| obr_req | input | 1 | Unmapped-read strobe; inputs sampled this cycle |
| compact_mode | input | 1 | 1 = 16-bit compact mode, 0 = 32-bit instruction mode |
| pf_word | input | 32 | Prefetched opcode word |
| dec_half | input | 16 | Low halfword of the decoded opcode |
| pc_page | input | 8 | Program counter bits 31:24 |
| pc_lo | input | 2 | Program counter bits 1:0 |
| addr_lo | input | 2 | Byte offset of the faulting access |
| obr_data | output | 32 | Registered, lane-shifted result |
| obr_valid | output | 1 | High in the cycle after a request |

## Verification
Two functions act on the same request in the same cycle: halfword assembly chosen by page and alignment, and the byte-lane shift. The bench crosses every page class with every `pc_lo` and every `addr_lo` value in both modes. Each result is compared with a word the bench builds arithmetically. A second pair that meets on one edge is request capture and output hold. After every request the bench drops the strobe and scrambles all data inputs, then checks that the output and flag behave as R8 says.

// File: rtl/obr_pkg.sv
package obr_pkg;
  typedef enum logic [1:0] {
    PG_PIPE_HI = 2'd0,
    PG_FAST    = 2'd1,
    PG_OTHER   = 2'd2
  } page_kind_e;
endpackage

// File: rtl/obr_page_classify.sv
module obr_page_classify
  import obr_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int LO_W   = 2,
  parameter logic [PAGE_W-1:0] PIPE_PAGE_A = 8'h00,
  parameter logic [PAGE_W-1:0] PIPE_PAGE_B = 8'h07,
  parameter logic [PAGE_W-1:0] FAST_PAGE   = 8'h03
) (
  input  logic [PAGE_W-1:0] pc_page,
  input  logic [LO_W-1:0]   pc_lo,
  output page_kind_e        kind,
  output logic              word_aligned
);
  function automatic page_kind_e classify(input logic [PAGE_W-1:0] pg);
    if (pg == PIPE_PAGE_A || pg == PIPE_PAGE_B) return PG_PIPE_HI;
    if (pg == FAST_PAGE) return PG_FAST;
    return PG_OTHER;
  endfunction

  assign kind         = classify(pc_page);
  assign word_aligned = (pc_lo == '0);
endmodule

// File: rtl/obr_half_merge.sv
module obr_half_merge
  import obr_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              compact_mode,
  input  page_kind_e        kind,
  input  logic              word_aligned,
  input  logic [DATA_W-1:0] pf_word,
  input  logic [HALF_W-1:0] dec_half,
  output logic [DATA_W-1:0] merged
);
  function automatic logic [DATA_W-1:0] merge_halves(
    input page_kind_e k, input logic al,
    input logic [HALF_W-1:0] p, input logic [HALF_W-1:0] d);
    case (k)
      PG_PIPE_HI: return {p, d};
      PG_FAST:    return al ? {d, p} : {p, d};
      default:    return {p, p};
    endcase
  endfunction

  assign merged = compact_mode ? merge_halves(kind, word_aligned, pf_word[HALF_W-1:0], dec_half)
                               : pf_word;
endmodule

// File: rtl/obr_lane_shift.sv
module obr_lane_shift #(
  parameter int DATA_W = 32,
  localparam int NBYTES = DATA_W / 8,
  localparam int LANE_W = $clog2(NBYTES)
) (
  input  logic [DATA_W-1:0] word_in,
  input  logic [LANE_W-1:0] lane,
  output logic [DATA_W-1:0] word_out
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_comb begin
      word_out[b*8 +: 8] = 8'h00;
      for (int s = 0; s < NBYTES; s++) begin
        if (s == b + int'(lane)) word_out[b*8 +: 8] = word_in[s*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/obr_value_gen.sv
module obr_value_gen
  import obr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PAGE_W = 8,
  localparam int HALF_W = DATA_W / 2,
  localparam int NBYTES = DATA_W / 8,
  localparam int LANE_W = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              obr_req,
  input  logic              compact_mode,
  input  logic [DATA_W-1:0] pf_word,
  input  logic [HALF_W-1:0] dec_half,
  input  logic [PAGE_W-1:0] pc_page,
  input  logic [LANE_W-1:0] pc_lo,
  input  logic [LANE_W-1:0] addr_lo,
  output logic [DATA_W-1:0] obr_data,
  output logic              obr_valid
);
  page_kind_e        kind;
  logic              word_aligned;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] shifted;

  obr_page_classify #(.PAGE_W(PAGE_W), .LO_W(LANE_W)) u_classify (
    .pc_page(pc_page), .pc_lo(pc_lo), .kind(kind), .word_aligned(word_aligned));

  obr_half_merge #(.DATA_W(DATA_W)) u_merge (
    .compact_mode(compact_mode), .kind(kind), .word_aligned(word_aligned),
    .pf_word(pf_word), .dec_half(dec_half), .merged(merged));

  obr_lane_shift #(.DATA_W(DATA_W)) u_shift (
    .word_in(merged), .lane(addr_lo), .word_out(shifted));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      obr_data  <= '0;
      obr_valid <= 1'b0;
    end else begin
      obr_valid <= obr_req;
      if (obr_req) obr_data <= shifted;
    end
  end

  a_r8_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    obr_req |=> obr_valid);
  a_r8_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !obr_req |=> !obr_valid);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !obr_req |=> $stable(obr_data));
  a_r2_wide_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (obr_req && !compact_mode && addr_lo == '0) |=> obr_data == $past(pf_word));
  a_r6_replicated: assert property (@(posedge clk) disable iff (!rst_n)
    (obr_req && compact_mode && kind == PG_OTHER && addr_lo == '0)
      |=> obr_data[DATA_W-1:HALF_W] == obr_data[HALF_W-1:0]);
  a_r7_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (obr_req && addr_lo == LANE_W'(NBYTES-1)) |=> obr_data[DATA_W-1:8] == '0);
  a_r4_fast_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (obr_req && compact_mode && kind == PG_FAST && word_aligned && addr_lo == '0)
      |=> obr_data[HALF_W-1:0] == $past(pf_word[HALF_W-1:0]));
endmodule

// File: tb/obr_value_gen_bench.sv
module obr_value_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        obr_req = 1'b0;
  logic        compact_mode = 1'b0;
  logic [31:0] pf_word = '0;
  logic [15:0] dec_half = '0;
  logic [7:0]  pc_page = '0;
  logic [1:0]  pc_lo = '0;
  logic [1:0]  addr_lo = '0;
  logic [31:0] obr_data;
  logic        obr_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  obr_value_gen u_obr_value_gen (
    .clk(clk), .rst_n(rst_n), .obr_req(obr_req), .compact_mode(compact_mode),
    .pf_word(pf_word), .dec_half(dec_half), .pc_page(pc_page), .pc_lo(pc_lo),
    .addr_lo(addr_lo), .obr_data(obr_data), .obr_valid(obr_valid));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic string req_of(input bit m, input logic [7:0] pg, input logic [1:0] lo);
    if (!m) return "R2";
    if (pg == 8'h00 || pg == 8'h07) return "R3";
    if (pg == 8'h03) return (lo == 2'd0) ? "R4" : "R5";
    return "R6";
  endfunction

  function automatic logic [31:0] expect_word(input bit m, input logic [31:0] pf,
      input logic [15:0] d, input logic [7:0] pg, input logic [1:0] lo, input logic [1:0] ln);
    logic [31:0] w;
    logic [15:0] p;
    p = pf[15:0];
    if (!m) w = pf;
    else if (pg == 8'h00 || pg == 8'h07) w = (32'(p) << 16) + 32'(d);
    else if (pg == 8'h03 && lo == 2'd0) w = (32'(d) << 16) + 32'(p);
    else if (pg == 8'h03) w = (32'(p) << 16) + 32'(d);
    else w = 32'(p) * 32'h0001_0001;
    return w / (32'd1 << (8 * ln));
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] pages [6] = '{8'h00, 8'h03, 8'h07, 8'h05, 8'hFF, 8'h08};
    logic [31:0] exp, held;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {31'd0, obr_valid}, 32'd0);
    check("R1 data in reset", obr_data, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after release", {31'd0, obr_valid}, 32'd0);
    check("R1 data after release", obr_data, 32'd0);

    for (int m = 0; m < 2; m++)
      for (int pi = 0; pi < 6; pi++)
        for (int lo = 0; lo < 4; lo++)
          for (int ln = 0; ln < 4; ln++) begin
            compact_mode = m[0];
            pf_word  = $urandom;
            dec_half = 16'($urandom);
            pc_page  = pages[pi];
            pc_lo    = lo[1:0];
            addr_lo  = ln[1:0];
            obr_req  = 1'b1;
            exp = expect_word(m[0], pf_word, dec_half, pc_page, lo[1:0], ln[1:0]);
            @(negedge clk);
            check({req_of(m[0], pages[pi], lo[1:0]), "/R7 data"}, obr_data, exp);
            check("R8 valid after request", {31'd0, obr_valid}, 32'd1);
            held = obr_data;
            obr_req = 1'b0;
            pf_word = ~pf_word; dec_half = ~dec_half;
            pc_page = pc_page + 8'd1; addr_lo = addr_lo + 2'd1;
            compact_mode = ~compact_mode;
            @(negedge clk);
            check("R8 hold without request", obr_data, held);
            check("R8 valid low without request", {31'd0, obr_valid}, 32'd0);
          end

    // R9: upper prefetched half changes alone, compact mode result unchanged
    for (int k = 0; k < 4; k++) begin
      compact_mode = 1'b1; pc_page = pages[k]; pc_lo = 2'd0; addr_lo = 2'd0;
      pf_word = {16'h0000, 16'hA55A}; dec_half = 16'h3CC3; obr_req = 1'b1;
      @(negedge clk);
      held = obr_data;
      pf_word = {16'hFFFF, 16'hA55A};
      @(negedge clk);
      check("R9 upper prefetch ignored", obr_data, held);
      obr_req = 1'b0;
      @(negedge clk);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule